// File: doc/BRIEF.md
# Timer Compare/Capture Pin Controller

This block holds one 16-bit general register of a timer channel together with the logic that serves the pin tied to it. A 4-bit mode field decides what the register does. In compare modes the pin is first forced to a start level that the mode itself carries. After that, each counter tick on which the counter equals the register clears, sets or inverts the pin. In capture modes the register takes a snapshot of the counter. The trigger is either an edge on the pin or a count event from a neighbouring channel.

The counter, its tick strobe, the neighbour's count event and the neighbour's prescaler select all arrive from outside. The CPU writes the mode field and the register through simple write strobes. Every compare match and every capture sets a sticky event flag. That flag drives an interrupt request through an enable. A buffer-mode input turns the register into a plain holding register, and then no compare or capture action occurs.

Top module: `tmr_ccp`

## Requirements
- R1: After reset, pin_out is 0, pin_oe is 0, evt_flag is 0, irq is 0 and reg_q is all ones.
- R2: Modes 4'b0000 and 4'b0100 keep pin_oe at 0, and a compare match leaves pin_out unchanged. The match still sets evt_flag.
- R3: Modes 4'b0001, 4'b0010 and 4'b0011 load pin_out with 0 on the clock after the mode write. A later compare match then drives 0, drives 1 or inverts pin_out, in that order of code.
- R4: Modes 4'b0101, 4'b0110 and 4'b0111 load pin_out with 1 on the clock after the mode write. A later compare match then drives 0, drives 1 or inverts pin_out, in that order of code.
- R5: A compare match needs cnt_tick high while cnt_val equals reg_q. With equal values and no tick, or with a tick and unequal values, neither pin_out nor evt_flag changes.
- R6: Mode 4'b1000 copies cnt_val into reg_q on a rising pin edge and mode 4'b1001 on a falling edge. Modes 4'b1010 and 4'b1011 copy on either edge.
- R7: Modes 4'b11xx copy cnt_val into reg_q on every nbr_cnt_evt pulse. While nbr_psc is 3'b000, such a pulse does nothing: no copy, no flag and no irq.
- R8: While buf_mode is 1, no compare match and no capture occurs in any mode. reg_q, pin_out and evt_flag all hold.
- R9: evt_flag stays set until a flag_clr pulse with no new event in the same cycle. A new event in the clearing cycle wins. irq is high exactly when evt_flag and irq_en are both 1.
- R10: In capture modes (mode bit 3 = 1), pin_oe is 0. In compare modes whose low two bits are not 00, pin_oe is 1.
- R11: A reg_wr loads reg_wdata into reg_q on the next clock. If a capture happens in the same cycle, the captured counter value is stored instead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cnt_val | input | CNT_W | Current counter value |
| cnt_tick | input | 1 | Counter update strobe |
| nbr_cnt_evt | input | 1 | Neighbour channel count pulse |
| nbr_psc | input | PSC_W | Neighbour prescaler select |
| buf_mode | input | 1 | Register used as buffer |
| cfg_wr | input | 1 | Mode field write strobe |
| cfg_mode | input | 4 | New mode field value |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | CNT_W | Register write data |
| flag_clr | input | 1 | Clear pulse for the event flag |
| irq_en | input | 1 | Interrupt enable |
| pin_in | input | 1 | Asynchronous pin level |
| pin_out | output | 1 | Driven pin level |
| pin_oe | output | 1 | Pin output enable |
| reg_q | output | CNT_W | Register contents |
| evt_flag | output | 1 | Sticky match/capture flag |
| irq | output | 1 | Interrupt request |

## Verification
A corrupted mode register shows up at once as a wrong pin_oe, or as a wrong start level one clock after the mode write. A bad compare path shows on pin_out and evt_flag in the clock right after the matching tick. A faulty edge detector or source select shows on reg_q three clocks after a pin change, or one clock after a neighbour pulse. Each scenario captures a distinct counter value per trigger, so a capture taken on the wrong edge or source leaves the wrong number in reg_q.

// File: rtl/tmr_ccp_pkg.sv
package tmr_ccp_pkg;

   typedef enum logic [1:0] {
      ACT_HOLD   = 2'd0,
      ACT_LOW    = 2'd1,
      ACT_HIGH   = 2'd2,
      ACT_INVERT = 2'd3
   } cmp_act_e;

   typedef struct packed {
      logic     cap_en;
      logic     src_nbr;
      logic     cap_rise;
      logic     cap_fall;
      logic     drive_en;
      logic     start_lvl;
      cmp_act_e act;
   } mode_dec_t;

endpackage

// File: rtl/tmr_ccp_decode.sv
module tmr_ccp_decode
   import tmr_ccp_pkg::*;
(
   input  logic [3:0] mode,
   output mode_dec_t  dec
);
   always_comb begin
      dec = '0;
      dec.act = ACT_HOLD;
      if (mode[3]) begin
         dec.cap_en = 1'b1;
         if (mode[2]) begin
            dec.src_nbr = 1'b1;
         end else if (mode[1]) begin
            dec.cap_rise = 1'b1;
            dec.cap_fall = 1'b1;
         end else if (mode[0]) begin
            dec.cap_fall = 1'b1;
         end else begin
            dec.cap_rise = 1'b1;
         end
      end else begin
         dec.start_lvl = mode[2];
         dec.drive_en  = (mode[1:0] != 2'b00);
         dec.act       = cmp_act_e'(mode[1:0]);
      end
   end
endmodule

// File: rtl/tmr_ccp_edge.sv
module tmr_ccp_edge #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_in,
   output logic rise,
   output logic fall
);
   logic [SYNC_STAGES-1:0] sync_q;
   logic                   last_q;

   genvar gi;
   generate
      for (gi = 0; gi < SYNC_STAGES; gi++) begin : g_sync
         if (gi == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) sync_q[gi] <= 1'b0;
               else        sync_q[gi] <= pin_in;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) sync_q[gi] <= 1'b0;
               else        sync_q[gi] <= sync_q[gi-1];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) last_q <= 1'b0;
      else        last_q <= sync_q[SYNC_STAGES-1];
   end

   assign rise = sync_q[SYNC_STAGES-1] & ~last_q;
   assign fall = ~sync_q[SYNC_STAGES-1] & last_q;
endmodule

// File: rtl/tmr_ccp_pinout.sv
module tmr_ccp_pinout
   import tmr_ccp_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     load_start,
   input  logic     start_lvl,
   input  logic     match,
   input  cmp_act_e act,
   output logic     pin_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pin_q <= 1'b0;
      end else if (load_start) begin
         pin_q <= start_lvl;
      end else if (match) begin
         case (act)
            ACT_LOW:    pin_q <= 1'b0;
            ACT_HIGH:   pin_q <= 1'b1;
            ACT_INVERT: pin_q <= ~pin_q;
            default:    pin_q <= pin_q;
         endcase
      end
   end
endmodule

// File: rtl/tmr_ccp_core.sv
module tmr_ccp_core #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cap_evt,
   input  logic             match,
   input  logic [CNT_W-1:0] cnt_val,
   input  logic             reg_wr,
   input  logic [CNT_W-1:0] reg_wdata,
   input  logic             flag_clr,
   output logic [CNT_W-1:0] reg_q,
   output logic             flag_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       reg_q <= '1;
      else if (cap_evt) reg_q <= cnt_val;
      else if (reg_wr)  reg_q <= reg_wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                flag_q <= 1'b0;
      else if (cap_evt || match) flag_q <= 1'b1;
      else if (flag_clr)         flag_q <= 1'b0;
   end
endmodule

// File: rtl/tmr_ccp.sv
module tmr_ccp
   import tmr_ccp_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int PSC_W       = 3,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] cnt_val,
   input  logic             cnt_tick,
   input  logic             nbr_cnt_evt,
   input  logic [PSC_W-1:0] nbr_psc,
   input  logic             buf_mode,
   input  logic             cfg_wr,
   input  logic [3:0]       cfg_mode,
   input  logic             reg_wr,
   input  logic [CNT_W-1:0] reg_wdata,
   input  logic             flag_clr,
   input  logic             irq_en,
   input  logic             pin_in,
   output logic             pin_out,
   output logic             pin_oe,
   output logic [CNT_W-1:0] reg_q,
   output logic             evt_flag,
   output logic             irq
);
   generate
      if (CNT_W < 2 || CNT_W > 32) begin : g_bad_cnt_w
         $error("tmr_ccp: CNT_W must lie in 2..32");
      end
      if (PSC_W < 1) begin : g_bad_psc_w
         $error("tmr_ccp: PSC_W must be at least 1");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("tmr_ccp: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [3:0] mode_q;
   mode_dec_t  dec_cur;
   mode_dec_t  dec_new;
   logic       pin_rise;
   logic       pin_fall;
   logic       pin_trig;
   logic       nbr_trig;
   logic       cap_evt;
   logic       match;
   logic       load_start;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      mode_q <= 4'b0000;
      else if (cfg_wr) mode_q <= cfg_mode;
   end

   tmr_ccp_decode u_dec_cur (.mode(mode_q),   .dec(dec_cur));
   tmr_ccp_decode u_dec_new (.mode(cfg_mode), .dec(dec_new));

   tmr_ccp_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .pin_in (pin_in),
      .rise   (pin_rise),
      .fall   (pin_fall)
   );

   assign pin_trig   = (dec_cur.cap_rise & pin_rise) | (dec_cur.cap_fall & pin_fall);
   assign nbr_trig   = nbr_cnt_evt & (nbr_psc != '0);
   assign cap_evt    = ~buf_mode & dec_cur.cap_en & (dec_cur.src_nbr ? nbr_trig : pin_trig);
   assign match      = ~buf_mode & ~dec_cur.cap_en & cnt_tick & (cnt_val == reg_q);
   assign load_start = cfg_wr & ~dec_new.cap_en;

   tmr_ccp_pinout u_pinout (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_start (load_start),
      .start_lvl  (dec_new.start_lvl),
      .match      (match),
      .act        (dec_cur.act),
      .pin_q      (pin_out)
   );

   tmr_ccp_core #(.CNT_W(CNT_W)) u_core (
      .clk       (clk),
      .rst_n     (rst_n),
      .cap_evt   (cap_evt),
      .match     (match),
      .cnt_val   (cnt_val),
      .reg_wr    (reg_wr),
      .reg_wdata (reg_wdata),
      .flag_clr  (flag_clr),
      .reg_q     (reg_q),
      .flag_q    (evt_flag)
   );

   assign pin_oe = dec_cur.drive_en;
   assign irq    = evt_flag & irq_en;
endmodule

// File: rtl/tmr_ccp_chk.sv
module tmr_ccp_chk #(
   parameter int CNT_W = 16,
   parameter int PSC_W = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic [3:0]       mode_q,
   input logic [CNT_W-1:0] cnt_val,
   input logic             cnt_tick,
   input logic [PSC_W-1:0] nbr_psc,
   input logic             buf_mode,
   input logic             cfg_wr,
   input logic             reg_wr,
   input logic             flag_clr,
   input logic             irq_en,
   input logic             pin_out,
   input logic             pin_oe,
   input logic [CNT_W-1:0] reg_q,
   input logic             evt_flag,
   input logic             irq
);
   a_r10_capture_oe_low: assert property (@(posedge clk) disable iff (!rst_n)
      mode_q[3] |-> !pin_oe);

   a_r2_disabled_oe_low: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_q[3] && mode_q[1:0] == 2'b00) |-> !pin_oe);

   a_r8_buffer_freeze: assert property (@(posedge clk) disable iff (!rst_n)
      (buf_mode && !cfg_wr && !reg_wr) |=> ($stable(reg_q) && $stable(pin_out)));

   a_r7_psc_zero_no_capture: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q[3:2] == 2'b11 && nbr_psc == '0 && !reg_wr) |=> $stable(reg_q));

   a_r9_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_flag && !flag_clr) |=> evt_flag);

   a_r9_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_en |-> !irq);

   a_r3_invert_on_match: assert property (@(posedge clk) disable iff (!rst_n)
      (!buf_mode && !cfg_wr && !mode_q[3] && mode_q[1:0] == 2'b11 &&
       cnt_tick && cnt_val == reg_q) |=> (pin_out != $past(pin_out)));
endmodule

bind tmr_ccp tmr_ccp_chk #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_chk (.*);

// File: tb/tmr_ccp_bench.sv
module tmr_ccp_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] cnt_val = '0;
   logic        cnt_tick = 1'b0;
   logic        nbr_cnt_evt = 1'b0;
   logic [2:0]  nbr_psc = 3'b001;
   logic        buf_mode = 1'b0;
   logic        cfg_wr = 1'b0;
   logic [3:0]  cfg_mode = '0;
   logic        reg_wr = 1'b0;
   logic [15:0] reg_wdata = '0;
   logic        flag_clr = 1'b0;
   logic        irq_en = 1'b0;
   logic        pin_in = 1'b0;
   logic        pin_out, pin_oe, evt_flag, irq;
   logic [15:0] reg_q;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   tmr_ccp u_tmr_ccp (.*);

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic set_mode(input logic [3:0] m);
      cfg_mode = m; cfg_wr = 1'b1;
      @(negedge clk); cfg_wr = 1'b0;
   endtask

   task automatic set_reg(input logic [15:0] v);
      reg_wdata = v; reg_wr = 1'b1;
      @(negedge clk); reg_wr = 1'b0;
   endtask

   task automatic tick_at(input logic [15:0] v);
      cnt_val = v; cnt_tick = 1'b1;
      @(negedge clk); cnt_tick = 1'b0;
   endtask

   task automatic clear_flag();
      flag_clr = 1'b1;
      @(negedge clk); flag_clr = 1'b0;
   endtask

   task automatic pin_to(input logic lvl, input logic [15:0] c);
      cnt_val = c; pin_in = lvl;
      repeat (4) @(negedge clk);
   endtask

   task automatic nbr_pulse(input logic [15:0] c);
      cnt_val = c; nbr_cnt_evt = 1'b1;
      @(negedge clk); nbr_cnt_evt = 1'b0;
   endtask

   task automatic t_reset();
      chk("R1", "pin_out", pin_out, 0);
      chk("R1", "pin_oe", pin_oe, 0);
      chk("R1", "evt_flag", evt_flag, 0);
      chk("R1", "irq", irq, 0);
      chk("R1", "reg_q", reg_q, 16'hFFFF);
   endtask

   task automatic t_out_disabled();
      logic p;
      set_reg(16'h0010);
      set_mode(4'b0100);
      p = pin_out;
      chk("R2", "oe 0100", pin_oe, 0);
      tick_at(16'h0010);
      chk("R2", "pin held 0100", pin_out, p);
      chk("R2", "flag on match", evt_flag, 1);
      clear_flag();
      set_mode(4'b0000);
      p = pin_out;
      chk("R2", "oe 0000", pin_oe, 0);
      tick_at(16'h0010);
      chk("R2", "pin held 0000", pin_out, p);
      clear_flag();
   endtask

   task automatic t_cmp_low();
      set_reg(16'h0040);
      set_mode(4'b0011);
      chk("R3", "start 0011", pin_out, 0);
      chk("R10", "oe 0011", pin_oe, 1);
      tick_at(16'h0040);
      chk("R3", "invert 1", pin_out, 1);
      tick_at(16'h0040);
      chk("R3", "invert 2", pin_out, 0);
      set_mode(4'b0010);
      chk("R3", "start 0010", pin_out, 0);
      tick_at(16'h0040);
      chk("R3", "high on match", pin_out, 1);
      tick_at(16'h0040);
      chk("R3", "high again", pin_out, 1);
      set_mode(4'b0001);
      chk("R3", "start 0001", pin_out, 0);
      tick_at(16'h0040);
      chk("R3", "low on match", pin_out, 0);
      clear_flag();
   endtask

   task automatic t_cmp_high();
      set_mode(4'b0101);
      chk("R4", "start 0101", pin_out, 1);
      tick_at(16'h0040);
      chk("R4", "low on match", pin_out, 0);
      set_mode(4'b0110);
      chk("R4", "start 0110", pin_out, 1);
      tick_at(16'h0040);
      chk("R4", "high on match", pin_out, 1);
      set_mode(4'b0111);
      chk("R4", "start 0111", pin_out, 1);
      tick_at(16'h0040);
      chk("R4", "invert 1", pin_out, 0);
      tick_at(16'h0040);
      chk("R4", "invert 2", pin_out, 1);
      clear_flag();
   endtask

   task automatic t_no_tick();
      set_mode(4'b0011);
      cnt_val = 16'h0040;
      repeat (2) @(negedge clk);
      chk("R5", "no tick pin", pin_out, 0);
      chk("R5", "no tick flag", evt_flag, 0);
      tick_at(16'h0041);
      chk("R5", "unequal pin", pin_out, 0);
      chk("R5", "unequal flag", evt_flag, 0);
   endtask

   task automatic t_pin_capture();
      set_mode(4'b1000);
      chk("R10", "oe capture", pin_oe, 0);
      pin_to(1'b1, 16'h1111);
      pin_to(1'b0, 16'h2222);
      chk("R6", "rising only", reg_q, 16'h1111);
      chk("R6", "capture flag", evt_flag, 1);
      clear_flag();
      set_mode(4'b1001);
      pin_to(1'b1, 16'h3333);
      pin_to(1'b0, 16'h4444);
      chk("R6", "falling only", reg_q, 16'h4444);
      set_mode(4'b1011);
      pin_to(1'b1, 16'h5555);
      chk("R6", "both rise", reg_q, 16'h5555);
      pin_to(1'b0, 16'h6666);
      chk("R6", "both fall", reg_q, 16'h6666);
      clear_flag();
   endtask

   task automatic t_neighbour();
      irq_en = 1'b1;
      set_mode(4'b1100);
      nbr_psc = 3'b001;
      nbr_pulse(16'h0ABC);
      chk("R7", "nbr capture", reg_q, 16'h0ABC);
      chk("R7", "nbr flag", evt_flag, 1);
      clear_flag();
      nbr_psc = 3'b000;
      nbr_pulse(16'h0DEF);
      chk("R7", "psc0 reg", reg_q, 16'h0ABC);
      chk("R7", "psc0 flag", evt_flag, 0);
      chk("R7", "psc0 irq", irq, 0);
      nbr_psc = 3'b001;
      irq_en = 1'b0;
   endtask

   task automatic t_buffer();
      logic p;
      buf_mode = 1'b1;
      set_mode(4'b1000);
      pin_to(1'b1, 16'h7777);
      pin_to(1'b0, 16'h7778);
      chk("R8", "no capture", reg_q, 16'h0ABC);
      chk("R8", "no capture flag", evt_flag, 0);
      set_mode(4'b0011);
      set_reg(16'h0020);
      p = pin_out;
      tick_at(16'h0020);
      chk("R8", "no compare pin", pin_out, p);
      chk("R8", "no compare flag", evt_flag, 0);
      buf_mode = 1'b0;
   endtask

   task automatic t_flag();
      set_mode(4'b0010);
      set_reg(16'h0030);
      irq_en = 1'b0;
      tick_at(16'h0030);
      chk("R9", "flag set", evt_flag, 1);
      chk("R9", "irq masked", irq, 0);
      irq_en = 1'b1;
      #1;
      chk("R9", "irq enabled", irq, 1);
      cnt_val = 16'h0030; cnt_tick = 1'b1; flag_clr = 1'b1;
      @(negedge clk); cnt_tick = 1'b0; flag_clr = 1'b0;
      chk("R9", "set beats clear", evt_flag, 1);
      clear_flag();
      chk("R9", "cleared", evt_flag, 0);
      chk("R9", "irq dropped", irq, 0);
      irq_en = 1'b0;
   endtask

   task automatic t_priority();
      set_mode(4'b1100);
      set_reg(16'h00AA);
      chk("R11", "write next clock", reg_q, 16'h00AA);
      cnt_val = 16'h5555; nbr_cnt_evt = 1'b1;
      reg_wdata = 16'h1234; reg_wr = 1'b1;
      @(negedge clk); nbr_cnt_evt = 1'b0; reg_wr = 1'b0;
      chk("R11", "capture wins", reg_q, 16'h5555);
      clear_flag();
   endtask

   initial begin
      #(8 * 50000);
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_out_disabled();
      t_cmp_low();
      t_cmp_high();
      t_no_tick();
      t_pin_capture();
      t_neighbour();
      t_buffer();
      t_flag();
      t_priority();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule